// File: doc/BRIEF.md
# Register and Immediate Shift Unit

This block is the shift datapath of a processor execute stage. It is purely combinational: given a 32-bit operand, a shift count and a small operation code, it produces the shifted result in the same cycle. The count comes either from a full 32-bit register value or from a 5-bit immediate field carried in the low half of the instruction word.

Register-count shifts cover logical left, logical right and arithmetic right. Counts that exceed the word width saturate rather than wrap. Immediate-count shifts cover the same three kinds plus rotate-left. In every immediate form an immediate of zero is given a second meaning. For the three plain shifts it means "shift by one and capture the bit that falls out in carry". For the rotate form it means "shift right by one, feeding the current carry in at the top and capturing bit 0 in carry".

The unit reports a new carry value with a write enable. Register decode and the register file sit outside it.

Top module: `reg_imm_shifter`

## Requirements
- R1: Operation code 0 (left shift by register) returns operand shifted left by reg_amount_i when reg_amount_i is at most 31, and zero for any larger value.
- R2: Operation code 1 (logical right shift by register) returns operand shifted right with zero fill when reg_amount_i is at most 31, and zero for any larger value.
- R3: Operation code 2 (arithmetic right shift by register) returns the sign-filled right shift when reg_amount_i is at most 31. For larger values it returns all ones if operand bit 31 is set and zero otherwise.
- R4: For operation codes 0, 1 and 2, carry_we_o is 0 and carry_o equals carry_i.
- R5: The immediate is instr_i[8:4]. The other instr_i bits have no effect on any output.
- R6: Operation codes 3, 4 and 5 (left, logical right and arithmetic right by immediate) with a non-zero immediate shift by that amount. They hold carry_we_o at 0 and carry_o equal to carry_i.
- R7: Operation codes 3, 4 and 5 with an immediate of zero shift by exactly one and drive carry_we_o to 1. carry_o is then operand bit 31 for the left shift and operand bit 0 for the two right shifts.
- R8: Operation code 6 with a non-zero immediate n returns the operand rotated left by n, with carry_we_o 0 and carry_o equal to carry_i.
- R9: Operation code 6 with an immediate of zero returns {carry_i, operand[31:1]}, with carry_o equal to operand bit 0 and carry_we_o 1.
- R10: Operation code 7 returns the operand unchanged, with carry_we_o 0 and carry_o equal to carry_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be shifted |
| reg_amount_i | input | 32 | Register-supplied shift count, used by codes 0 to 2 |
| instr_i | input | 16 | Instruction half-word; the immediate count is bits [8:4] |
| op_i | input | 3 | Operation code (0 to 7 as listed in the requirements) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted result |
| carry_o | output | 1 | New carry value (equals carry_i when not written) |
| carry_we_o | output | 1 | High when the carry flag is to be written |

## Verification
The hardest cases to reach are the register counts near and far past the word width. A value such as 0x0000_0020, or one with only upper bits set, would wrap to a small shift if the saturation looked only at the low five bits. The sweep therefore drives every count from 0 to 40 along with counts that have only high bits set. Each of these is applied to positive, negative, alternating and single-bit operands. The immediate sweeps cover all 32 immediates for every immediate opcode with both carry values. They also place noise in the instruction bits around the immediate field, which shows whether the zero-immediate carry path is decoded from the correct field.

// File: rtl/shf_pkg.sv
package shf_pkg;

  // Operation codes seen at op_i
  typedef enum logic [2:0] {
    OP_LSL_REG = 3'd0,
    OP_LSR_REG = 3'd1,
    OP_ASR_REG = 3'd2,
    OP_LSL_IMM = 3'd3,
    OP_LSR_IMM = 3'd4,
    OP_ASR_IMM = 3'd5,
    OP_ROT_IMM = 3'd6,
    OP_PASS    = 3'd7
  } shf_op_e;

  // Datapath shape selected by the decoder
  typedef enum logic [1:0] {
    K_PASS  = 2'd0,
    K_LEFT  = 2'd1,
    K_RIGHT = 2'd2,
    K_ROTL  = 2'd3
  } shf_kind_e;

endpackage

// File: rtl/shf_amount_dec.sv
module shf_amount_dec
  import shf_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int INSTR_W = 16,
  parameter int IMM_LSB = 4,
  localparam int AW     = $clog2(WIDTH)
) (
  input  logic [2:0]         op_i,
  input  logic [WIDTH-1:0]   reg_amount_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               sign_i,
  input  logic               carry_i,
  output shf_kind_e          kind_o,
  output logic               fill_o,
  output logic [AW:0]        amt_o,
  output logic               cwe_o,
  output logic               csel_msb_o
);

  logic [AW-1:0] imm;
  logic          imm_zero;
  logic          reg_over;
  logic [AW:0]   reg_amt_sat;
  logic [AW:0]   imm_amt;
  shf_op_e       op;

  assign op       = shf_op_e'(op_i);
  assign imm      = instr_i[IMM_LSB +: AW];
  assign imm_zero = (imm == '0);
  // counts that do not fit below WIDTH clamp to exactly WIDTH
  assign reg_over    = |reg_amount_i[WIDTH-1:AW];
  assign reg_amt_sat = reg_over ? (AW+1)'(WIDTH) : {1'b0, reg_amount_i[AW-1:0]};
  // zero immediate stands for a single-bit shift through carry
  assign imm_amt     = imm_zero ? (AW+1)'(1) : {1'b0, imm};

  always_comb begin
    kind_o     = K_PASS;
    fill_o     = 1'b0;
    amt_o      = '0;
    cwe_o      = 1'b0;
    csel_msb_o = 1'b0;
    unique case (op)
      OP_LSL_REG: begin kind_o = K_LEFT;  amt_o = reg_amt_sat; end
      OP_LSR_REG: begin kind_o = K_RIGHT; amt_o = reg_amt_sat; end
      OP_ASR_REG: begin kind_o = K_RIGHT; amt_o = reg_amt_sat; fill_o = sign_i; end
      OP_LSL_IMM: begin
        kind_o = K_LEFT;  amt_o = imm_amt; cwe_o = imm_zero; csel_msb_o = 1'b1;
      end
      OP_LSR_IMM: begin
        kind_o = K_RIGHT; amt_o = imm_amt; cwe_o = imm_zero;
      end
      OP_ASR_IMM: begin
        kind_o = K_RIGHT; amt_o = imm_amt; cwe_o = imm_zero; fill_o = sign_i;
      end
      OP_ROT_IMM: begin
        if (imm_zero) begin
          kind_o = K_RIGHT; amt_o = (AW+1)'(1); fill_o = carry_i; cwe_o = 1'b1;
        end else begin
          kind_o = K_ROTL;  amt_o = {1'b0, imm};
        end
      end
      default: kind_o = K_PASS;
    endcase
  end

  // R1
  always_comb begin
    amt_range_chk: assert (amt_o <= (AW+1)'(WIDTH))
      else $error("shift count above word width");
  end

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] x_i,
  input  shf_kind_e        kind_i,
  input  logic             fill_i,
  input  logic [AW:0]      amt_i,
  output logic [WIDTH-1:0] y_o
);

  logic [2*WIDTH-1:0] right_src;
  logic [2*WIDTH-1:0] left_src;
  logic [2*WIDTH-1:0] rot_src;

  assign right_src = {{WIDTH{fill_i}}, x_i};
  assign left_src  = {{WIDTH{1'b0}}, x_i};
  assign rot_src   = {x_i, x_i};

  always_comb begin
    unique case (kind_i)
      K_LEFT:  y_o = WIDTH'(left_src << amt_i);
      K_RIGHT: y_o = WIDTH'(right_src >> amt_i);
      K_ROTL:  y_o = WIDTH'((rot_src << amt_i) >> WIDTH);
      default: y_o = x_i;
    endcase
  end

  // R1
  always_comb begin
    lsl_sat_chk: assert (!(kind_i == K_LEFT && amt_i == (AW+1)'(WIDTH)) || y_o == '0)
      else $error("saturated left shift not zero");
  end

  // R3
  always_comb begin
    asr_sat_chk: assert (!(kind_i == K_RIGHT && amt_i == (AW+1)'(WIDTH)) || y_o == {WIDTH{fill_i}})
      else $error("saturated right shift not fill");
  end

endmodule

// File: rtl/reg_imm_shifter.sv
module reg_imm_shifter
  import shf_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int INSTR_W = 16,
  parameter int IMM_LSB = 4,
  localparam int AW     = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   operand_i,
  input  logic [WIDTH-1:0]   reg_amount_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [2:0]         op_i,
  input  logic               carry_i,
  output logic [WIDTH-1:0]   result_o,
  output logic               carry_o,
  output logic               carry_we_o
);

  shf_kind_e   kind;
  logic        fill;
  logic [AW:0] amt;
  logic        cwe;
  logic        csel_msb;

  shf_amount_dec #(
    .WIDTH(WIDTH), .INSTR_W(INSTR_W), .IMM_LSB(IMM_LSB)
  ) u_dec (
    .op_i        (op_i),
    .reg_amount_i(reg_amount_i),
    .instr_i     (instr_i),
    .sign_i      (operand_i[WIDTH-1]),
    .carry_i     (carry_i),
    .kind_o      (kind),
    .fill_o      (fill),
    .amt_o       (amt),
    .cwe_o       (cwe),
    .csel_msb_o  (csel_msb)
  );

  shf_datapath #(.WIDTH(WIDTH)) u_dp (
    .x_i   (operand_i),
    .kind_i(kind),
    .fill_i(fill),
    .amt_i (amt),
    .y_o   (result_o)
  );

  // bit that leaves the word on a single-bit shift
  assign carry_we_o = cwe;
  assign carry_o    = cwe ? (csel_msb ? operand_i[WIDTH-1] : operand_i[0]) : carry_i;

  // R4
  always_comb begin
    reg_carry_hold_chk: assert (op_i > 3'd2 || (!carry_we_o && carry_o == carry_i))
      else $error("register shift touched carry");
  end

  // R9
  always_comb begin
    xsr_top_bit_chk: assert (!(op_i == 3'd6 && instr_i[IMM_LSB +: AW] == '0)
                             || (result_o[WIDTH-1] == carry_i && carry_we_o))
      else $error("extended shift lost carry");
  end

endmodule

// File: tb/reg_imm_shifter_bench.sv
module reg_imm_shifter_bench;

  logic        clk = 1'b0;
  logic [31:0] operand;
  logic [31:0] reg_amount;
  logic [15:0] instr;
  logic [2:0]  op;
  logic        cin;
  logic [31:0] result;
  logic        cout;
  logic        cwe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  reg_imm_shifter u_reg_imm_shifter (
    .operand_i   (operand),
    .reg_amount_i(reg_amount),
    .instr_i     (instr),
    .op_i        (op),
    .carry_i     (cin),
    .result_o    (result),
    .carry_o     (cout),
    .carry_we_o  (cwe)
  );

  localparam longint unsigned M32 = 64'hFFFF_FFFF;

  function automatic logic [31:0] pw2(input int n);
    longint unsigned p = 1;
    for (int i = 0; i < n; i++) p = p * 2;
    return p[31:0];
  endfunction

  function automatic logic [31:0] m_lsl(input logic [31:0] x, input int n);
    longint unsigned v;
    if (n > 31) return 32'h0;
    v = longint'(x) * longint'(pw2(n));
    return v[31:0];
  endfunction

  function automatic logic [31:0] m_lsr(input logic [31:0] x, input int n);
    if (n > 31) return 32'h0;
    return x / pw2(n);
  endfunction

  function automatic logic [31:0] m_asr(input logic [31:0] x, input int n);
    logic [31:0] base;
    if (n > 31) return x[31] ? 32'hFFFF_FFFF : 32'h0;
    base = x / pw2(n);
    if (x[31] && n > 0) base = base + (32'hFFFF_FFFF - (32'hFFFF_FFFF / pw2(n)));
    return base;
  endfunction

  function automatic logic [31:0] m_rol(input logic [31:0] x, input int n);
    return m_lsl(x, n) | m_lsr(x, 32 - n);
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic ec, input logic ew);
    checks++;
    if (result !== er || cout !== ec || cwe !== ew) begin
      fails++;
      $display("FAIL %s op=%0d x=%h amt=%h instr=%h cin=%b: got res=%h c=%b we=%b exp res=%h c=%b we=%b",
               req, op, operand, reg_amount, instr, cin, result, cout, cwe, er, ec, ew);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [31:0] x, input logic [31:0] ra,
                       input logic [15:0] ins, input logic c);
    @(negedge clk);
    op = o; operand = x; reg_amount = ra; instr = ins; cin = c;
    #1;
  endtask

  logic [31:0] pats [6] = '{32'h0000_0000, 32'h8000_0001, 32'hA5A5_5A5A,
                            32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0001_0000};

  initial begin
    // idle state: all zero inputs, op 0
    apply(3'd0, 32'h0, 32'h0, 16'h0, 1'b0);
    check("R1 idle", 32'h0, 1'b0, 1'b0);

    // R1 R2 R3 R4: register counts 0..40 plus high-bit-only counts
    for (int p = 0; p < 6; p++) begin
      for (int a = 0; a < 44; a++) begin
        logic [31:0] ra;
        int          ne;
        ra = (a < 41) ? 32'(a) : (a == 41 ? 32'h8000_0000 : (a == 42 ? 32'h0000_0100 : 32'hFFFF_FFE1));
        ne = (a < 41) ? a : 99;
        for (int c = 0; c < 2; c++) begin
          apply(3'd0, pats[p], ra, 16'hFFFF, 1'(c));
          check("R1/R4 lsl reg", m_lsl(pats[p], ne), 1'(c), 1'b0);
          apply(3'd1, pats[p], ra, 16'h0000, 1'(c));
          check("R2/R4 lsr reg", m_lsr(pats[p], ne), 1'(c), 1'b0);
          apply(3'd2, pats[p], ra, 16'h0000, 1'(c));
          check("R3/R4 asr reg", m_asr(pats[p], ne), 1'(c), 1'b0);
        end
      end
    end

    // R5 R6 R7 R8 R9: every immediate, noise outside bits [8:4]
    for (int p = 0; p < 6; p++) begin
      for (int n = 0; n < 32; n++) begin
        for (int c = 0; c < 2; c++) begin
          logic [15:0] ins;
          ins = (16'hFE0F & (16'h9E0B ^ 16'(p * 16'h1111 + n))) | 16'(n << 4);
          apply(3'd3, pats[p], 32'hFFFF_FFFF, ins, 1'(c));
          if (n == 0) check("R7/R5 lsl imm0", m_lsl(pats[p], 1), pats[p][31], 1'b1);
          else        check("R6/R5 lsl imm",  m_lsl(pats[p], n), 1'(c), 1'b0);
          apply(3'd4, pats[p], 32'h0, ins, 1'(c));
          if (n == 0) check("R7/R5 lsr imm0", m_lsr(pats[p], 1), pats[p][0], 1'b1);
          else        check("R6/R5 lsr imm",  m_lsr(pats[p], n), 1'(c), 1'b0);
          apply(3'd5, pats[p], 32'h0, ins, 1'(c));
          if (n == 0) check("R7/R5 asr imm0", m_asr(pats[p], 1), pats[p][0], 1'b1);
          else        check("R6/R5 asr imm",  m_asr(pats[p], n), 1'(c), 1'b0);
          apply(3'd6, pats[p], 32'h5, ins, 1'(c));
          if (n == 0) check("R9 xsr", m_lsr(pats[p], 1) | (c ? 32'h8000_0000 : 32'h0), pats[p][0], 1'b1);
          else        check("R8 rotl", m_rol(pats[p], n), 1'(c), 1'b0);
        end
      end
    end

    // R10: unused code passes operand through
    for (int p = 0; p < 6; p++) begin
      apply(3'd7, pats[p], 32'h3, 16'h0000, 1'(p & 1));
      check("R10 pass", pats[p], 1'(p & 1), 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule